// File: doc/BRIEF.md
# Learning Forwarding Table for a Six-Port Switch

This block is the address-resolution engine of a six-port store-and-forward switch. For every frame the switch has buffered, the frame processor hands the engine one request. The request carries the source address, the destination address, the filtering identifier (FID), the ingress port number and the ingress port's group membership mask. The engine answers with an egress port mask. It also remembers which port the sender lives on, so that later traffic addressed to that station goes to one port only.

Entries are keyed on the 48-bit address together with the FID, so the same station address can live in different filtering domains at the same time. The table is set associative and sits in on-chip registers. A set is chosen by XOR-folding the key down to the index width. Four ways per set hold full tags. A set that is full is refilled in round-robin order. A single-cycle flush input empties the whole table.

A request is taken only while the engine is idle. The engine stays busy while it resolves the destination and then learns the source. It then raises a one-cycle response strobe. The next frame's lookup therefore always sees what the previous frame taught the table.

Top module: `fdb_engine`

## Requirements
- R1: An entry matches only when both its address and its FID equal the key. The key is {FID, address}, with the FID in the upper bits. Set index bit j is the XOR of every key bit i with i mod IDX_W equal to j.
- R2: When the destination is a unicast address and {FID, destination} hits, the mask contains only the stored port's bit, and rspHit is 1. If the stored port is the ingress port, the mask is 0.
- R3: When a unicast destination misses, the mask is the group mask with the ingress port's bit cleared, and rspHit is 0.
- R4: A destination whose group bit (address bit 40) is 1 is never looked up. It floods as in R3 with rspHit 0, even when that address has been learned.
- R5: The lookup for a frame happens before that frame's source is learned. A frame whose source equals its destination, with no prior entry, therefore floods.
- R6: An absent source key is inserted, bound to the ingress port, into the lowest-numbered empty way of its set.
- R7: A source key that is already present but bound to another port is rebound to the ingress port in place. No second entry is created and the replacement pointer is not moved.
- R8: When the set is full, the new key goes into the way named by that set's round-robin pointer, and the pointer then advances by one. The pointer starts at way 0 after reset or flush.
- R9: A request is accepted on a clock edge where reqValid is 1 and busy is 0. busy is 1 for the three following cycles. rspValid is 1 only in the third of them, together with a valid mask. Requests presented while busy are ignored.
- R10: A flush cycle empties every entry and resets every replacement pointer. It wins over a learn write in the same cycle.
- R11: After reset, busy and rspValid are 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties the table in one cycle |
| reqValid | input | 1 | Request present |
| reqSa | input | ADDR_W | Source address |
| reqDa | input | ADDR_W | Destination address |
| reqFid | input | FID_W | Filtering identifier |
| reqPort | input | PORT_W | Ingress port number |
| reqGroup | input | NUM_PORTS | Group membership mask of the ingress port |
| busy | output | 1 | Engine is processing a frame |
| rspValid | output | 1 | One-cycle strobe: response fields are valid |
| rspMask | output | NUM_PORTS | Egress port mask |
| rspHit | output | 1 | Destination was found in the table |

## Verification
The bench builds the engine with IDX_W set to 2, so the table has four sets. All other parameters keep their defaults: six ports, 48-bit addresses, 4-bit FID and four ways. With only four sets, single-byte addresses whose 2-bit chunks cancel under XOR all land in set 0. A handful of frames then fills that set and drives the round-robin replacement, the in-place station move inside a full set, and FID-separated entries that share a set. Using the same index width, a probe station is parked in a different set so that its own learning never disturbs the set under test.

// File: rtl/fdb_pkg.sv
package fdb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_LEARN = 2'd2,
    ST_DONE  = 2'd3
  } fdbState_t;

  typedef struct packed {
    logic capture;   // latch the request fields
    logic doLookup;  // register the destination result
    logic doLearn;   // write the source binding
  } fdbCtrl_t;

endpackage

// File: rtl/fdb_hash.sv
module fdb_hash #(
  parameter int KEY_W = 52,
  parameter int IDX_W = 8
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);
  localparam int CHUNKS = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = CHUNKS * IDX_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(key);

  always_comb begin
    idx = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      idx = idx ^ padded[c*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/fdb_ctrl.sv
module fdb_ctrl
  import fdb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  output fdbCtrl_t ctl,
  output logic     busy,
  output logic     rspValid
);
  fdbState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (reqValid) stateD = ST_LOOK;
      ST_LOOK:  stateD = ST_LEARN;
      ST_LEARN: stateD = ST_DONE;
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  assign ctl.capture  = reqValid && (stateQ == ST_IDLE);
  assign ctl.doLookup = (stateQ == ST_LOOK);
  assign ctl.doLearn  = (stateQ == ST_LEARN);
  assign busy         = (stateQ != ST_IDLE);
  assign rspValid     = (stateQ == ST_DONE);

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid); // R9
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> ($past(busy, 2) && $past(busy))); // R9
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rspValid) |=> busy); // R9
endmodule

// File: rtl/fdb_datapath.sv
module fdb_datapath
  import fdb_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int ADDR_W    = 48,
  parameter int FID_W     = 4,
  parameter int IDX_W     = 8,
  parameter int WAYS      = 4,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  fdbCtrl_t             ctl,
  input  logic [ADDR_W-1:0]    reqSa,
  input  logic [ADDR_W-1:0]    reqDa,
  input  logic [FID_W-1:0]     reqFid,
  input  logic [PORT_W-1:0]    reqPort,
  input  logic [NUM_PORTS-1:0] reqGroup,
  output logic [NUM_PORTS-1:0] rspMask,
  output logic                 rspHit
);
  localparam int SETS      = 1 << IDX_W;
  localparam int WAY_W     = $clog2(WAYS);
  localparam int KEY_W     = ADDR_W + FID_W;
  localparam int GROUP_BIT = ADDR_W - 8;

  // latched request
  logic [ADDR_W-1:0]    saQ, daQ;
  logic [FID_W-1:0]     fidQ;
  logic [PORT_W-1:0]    portQ;
  logic [NUM_PORTS-1:0] groupQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saQ <= '0; daQ <= '0; fidQ <= '0; portQ <= '0; groupQ <= '0;
    end else if (ctl.capture) begin
      saQ <= reqSa; daQ <= reqDa; fidQ <= reqFid;
      portQ <= reqPort; groupQ <= reqGroup;
    end
  end

  // table storage
  logic [WAYS-1:0]   validQ   [SETS];
  logic [WAY_W-1:0]  rrQ      [SETS];
  logic [ADDR_W-1:0] addrTagQ [SETS][WAYS];
  logic [FID_W-1:0]  fidTagQ  [SETS][WAYS];
  logic [PORT_W-1:0] portTagQ [SETS][WAYS];

  // two hashed indices: destination and source
  logic [IDX_W-1:0] daIdx, saIdx;
  logic [KEY_W-1:0] hashKey [2];
  logic [IDX_W-1:0] hashIdx [2];
  assign hashKey[0] = {fidQ, daQ};
  assign hashKey[1] = {fidQ, saQ};

  for (genvar h = 0; h < 2; h++) begin : g_hash
    fdb_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
      .key(hashKey[h]),
      .idx(hashIdx[h])
    );
  end
  assign daIdx = hashIdx[0];
  assign saIdx = hashIdx[1];

  // per-way tag compare
  logic [WAYS-1:0] daMatch, saMatch;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign daMatch[w] = validQ[daIdx][w] && (addrTagQ[daIdx][w] == daQ) &&
                        (fidTagQ[daIdx][w] == fidQ);
    assign saMatch[w] = validQ[saIdx][w] && (addrTagQ[saIdx][w] == saQ) &&
                        (fidTagQ[saIdx][w] == fidQ);
  end

  logic [PORT_W-1:0] daPort;
  logic [WAY_W-1:0]  saWay;
  always_comb begin
    daPort = '0;
    saWay  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (daMatch[w]) daPort = portTagQ[daIdx][w];
      if (saMatch[w]) saWay  = WAY_W'(w);
    end
  end

  // destination resolution
  logic [NUM_PORTS-1:0] ingressHot, hitHot, maskD;
  logic                 hitD, daIsGroup;
  assign ingressHot = NUM_PORTS'(1) << portQ;
  assign hitHot     = NUM_PORTS'(1) << daPort;
  assign daIsGroup  = daQ[GROUP_BIT];

  always_comb begin
    if (!daIsGroup && (|daMatch)) begin
      maskD = hitHot & ~ingressHot;
      hitD  = 1'b1;
    end else begin
      maskD = groupQ & ~ingressHot;
      hitD  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspMask <= '0;
      rspHit  <= 1'b0;
    end else if (ctl.doLookup) begin
      rspMask <= maskD;
      rspHit  <= hitD;
    end
  end

  // source learning decision
  logic             wrEn, rrAdv, freeFound;
  logic [WAY_W-1:0] wrWay;
  always_comb begin
    wrEn      = 1'b0;
    rrAdv     = 1'b0;
    freeFound = 1'b0;
    wrWay     = '0;
    if (|saMatch) begin
      wrWay = saWay;
      wrEn  = (portTagQ[saIdx][saWay] != portQ);
    end else begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!validQ[saIdx][w]) begin
          wrWay     = WAY_W'(w);
          freeFound = 1'b1;
        end
      end
      if (!freeFound) begin
        wrWay = rrQ[saIdx];
        rrAdv = 1'b1;
      end
      wrEn = 1'b1;
    end
    wrEn  = wrEn  && ctl.doLearn;
    rrAdv = rrAdv && ctl.doLearn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        rrQ[s]    <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        rrQ[s]    <= '0;
      end
    end else begin
      if (wrEn)  validQ[saIdx][wrWay] <= 1'b1;
      if (rrAdv) rrQ[saIdx] <= rrQ[saIdx] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      addrTagQ[saIdx][wrWay] <= saQ;
      fidTagQ[saIdx][wrWay]  <= fidQ;
      portTagQ[saIdx][wrWay] <= portQ;
    end
  end

  logic anyValid;
  always_comb begin
    anyValid = 1'b0;
    for (int s = 0; s < SETS; s++) anyValid = anyValid | (|validQ[s]);
  end

  AST_MASK_NO_INGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doLearn |-> ((rspMask & ingressHot) == '0)); // R2
  AST_HIT_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.doLearn && rspHit) |-> $onehot0(rspMask)); // R2
  AST_FLOOD_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.doLearn && !rspHit) |-> ((rspMask & ~groupQ) == '0)); // R3
  AST_GROUP_DA_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.doLearn && daIsGroup) |-> !rspHit); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !anyValid); // R10
endmodule

// File: rtl/fdb_engine.sv
module fdb_engine
  import fdb_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int ADDR_W    = 48,
  parameter int FID_W     = 4,
  parameter int IDX_W     = 8,
  parameter int WAYS      = 4,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqSa,
  input  logic [ADDR_W-1:0]    reqDa,
  input  logic [FID_W-1:0]     reqFid,
  input  logic [PORT_W-1:0]    reqPort,
  input  logic [NUM_PORTS-1:0] reqGroup,
  output logic                 busy,
  output logic                 rspValid,
  output logic [NUM_PORTS-1:0] rspMask,
  output logic                 rspHit
);
  fdbCtrl_t ctl;

  fdb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .ctl      (ctl),
    .busy     (busy),
    .rspValid (rspValid)
  );

  fdb_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .FID_W     (FID_W),
    .IDX_W     (IDX_W),
    .WAYS      (WAYS),
    .PORT_W    (PORT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .ctl      (ctl),
    .reqSa    (reqSa),
    .reqDa    (reqDa),
    .reqFid   (reqFid),
    .reqPort  (reqPort),
    .reqGroup (reqGroup),
    .rspMask  (rspMask),
    .rspHit   (rspHit)
  );
endmodule

// File: tb/tb_fdb_engine.sv
`timescale 1ns/1ps
module tb_fdb_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        reqValid = 1'b0;
  logic [47:0] reqSa = '0, reqDa = '0;
  logic [3:0]  reqFid = '0;
  logic [2:0]  reqPort = '0;
  logic [5:0]  reqGroup = '0;
  logic        busy, rspValid, rspHit;
  logic [5:0]  rspMask;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fdb_engine #(.IDX_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .reqValid(reqValid),
    .reqSa(reqSa), .reqDa(reqDa), .reqFid(reqFid), .reqPort(reqPort),
    .reqGroup(reqGroup), .busy(busy), .rspValid(rspValid),
    .rspMask(rspMask), .rspHit(rspHit)
  );

  typedef struct packed {
    logic [47:0] sa;
    logic [47:0] da;
    logic [3:0]  fid;
    logic [2:0]  port;
    logic [5:0]  grp;
    logic [5:0]  mask;
    logic        hit;
    logic [3:0]  req;
  } vec_t;

  // set 0 (IDX_W=2): 05, 0A, 0F, 11, 22, 33 ; set1: 01 ; set2: 02, 07 ; set3: 03
  localparam logic [47:0] A = 48'h05, B = 48'h0A, C = 48'h01, D = 48'h02;
  localparam logic [47:0] M = 48'h0100_0000_0001;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0100_0000_0000;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{A, B,  4'd0, 3'd0, 6'h3F, 6'h3E, 1'b0, 4'd3}, // R3 empty table floods
    '{B, A,  4'd0, 3'd1, 6'h3F, 6'h01, 1'b1, 4'd2}, // R2 learned A
    '{C, A,  4'd0, 3'd2, 6'h07, 6'h01, 1'b1, 4'd2}, // R2 hit ignores group
    '{D, BC, 4'd0, 3'd3, 6'h3F, 6'h37, 1'b0, 4'd4}, // R4 broadcast
    '{A, C,  4'd0, 3'd4, 6'h3F, 6'h04, 1'b1, 4'd2}, // R2, A moves to 4
    '{B, A,  4'd0, 3'd1, 6'h3F, 6'h10, 1'b1, 4'd7}, // R7 station move
    '{A, A,  4'd0, 3'd4, 6'h3F, 6'h00, 1'b1, 4'd2}, // R2 own port filtered
    '{C, MC, 4'd0, 3'd2, 6'h0F, 6'h0B, 1'b0, 4'd4}, // R4 multicast
    '{M, C,  4'd0, 3'd5, 6'h3F, 6'h04, 1'b1, 4'd2}, // R2, learns M
    '{D, M,  4'd0, 3'd3, 6'h30, 6'h30, 1'b0, 4'd4}, // R4 learned group addr floods
    '{C, A,  4'd1, 3'd2, 6'h3F, 6'h3B, 1'b0, 4'd1}, // R1 other FID misses
    '{D, C,  4'd1, 3'd3, 6'h3F, 6'h04, 1'b1, 4'd1}  // R1 FID-scoped hit
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [47:0] sa, input logic [47:0] da, input logic [3:0] fid,
                       input logic [2:0] port, input logic [5:0] grp,
                       output logic [5:0] m, output logic h, output logic v);
    @(negedge clk);
    reqSa = sa; reqDa = da; reqFid = fid; reqPort = port; reqGroup = grp;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    m = rspMask; h = rspHit; v = rspValid;
  endtask

  task automatic doFlush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  localparam logic [47:0] P = 48'h03;
  localparam logic [47:0] E = 48'h0F, F = 48'h11, G = 48'h22, H = 48'h33, X = 48'h07;

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] m;
    logic h, v;
    repeat (3) @(negedge clk);
    chk("R11 busy after reset", busy, 0);
    chk("R11 rspValid after reset", rspValid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy idle", busy, 0);

    for (int i = 0; i < NV; i++) begin
      frame(VECS[i].sa, VECS[i].da, VECS[i].fid, VECS[i].port, VECS[i].grp, m, h, v);
      chk($sformatf("R%0d vec%0d mask", VECS[i].req, i), m, VECS[i].mask);
      chk($sformatf("R%0d vec%0d hit", VECS[i].req, i), h, VECS[i].hit);
      chk($sformatf("R9 vec%0d rspValid", i), v, 1);
    end

    // R9 handshake timing and ignoring requests while busy
    doFlush();
    @(negedge clk);
    reqSa = E; reqDa = P; reqFid = 0; reqPort = 2; reqGroup = 6'h3F; reqValid = 1'b1;
    @(negedge clk);
    reqSa = G; reqPort = 3;
    @(negedge clk);
    chk("R9 busy cycle1", busy, 1);
    chk("R9 no early rsp", rspValid, 0);
    @(negedge clk);
    chk("R9 rsp at cycle3", rspValid, 1);
    chk("R9 busy with rsp", busy, 1);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R9 idle after rsp", busy, 0);
    chk("R9 rsp single pulse", rspValid, 0);
    @(negedge clk);
    chk("R9 no second rsp", rspValid, 0);
    frame(P, G, 0, 5, 6'h3F, m, h, v);
    chk("R9 busy request not learned", m, 6'h1F);
    frame(P, E, 0, 5, 6'h3F, m, h, v);
    chk("R9 accepted request learned", m, 6'h04);

    // R10 flush
    doFlush();
    frame(P, E, 0, 5, 6'h3F, m, h, v);
    chk("R10 flushed mask", m, 6'h1F);
    chk("R10 flushed hit", h, 0);

    // R6 / R8 fill set 0, then round-robin replacement
    doFlush();
    frame(A, P, 0, 0, 6'h3F, m, h, v);
    frame(B, P, 0, 1, 6'h3F, m, h, v);
    frame(E, P, 0, 2, 6'h3F, m, h, v);
    frame(F, P, 0, 3, 6'h3F, m, h, v);
    frame(P, F, 0, 5, 6'h3F, m, h, v);
    chk("R6 fourth way filled", m, 6'h08);
    frame(G, P, 0, 4, 6'h3F, m, h, v);
    frame(P, A, 0, 5, 6'h3F, m, h, v);
    chk("R8 way0 evicted first", m, 6'h1F);
    frame(P, B, 0, 5, 6'h3F, m, h, v);
    chk("R8 way1 kept", m, 6'h02);
    frame(E, P, 0, 1, 6'h3F, m, h, v);
    frame(H, P, 0, 0, 6'h3F, m, h, v);
    frame(P, B, 0, 5, 6'h3F, m, h, v);
    chk("R8 way1 evicted second", m, 6'h1F);
    frame(P, E, 0, 5, 6'h3F, m, h, v);
    chk("R7 move kept entry, no pointer step", m, 6'h02);
    frame(P, G, 0, 5, 6'h3F, m, h, v);
    chk("R8 replacement G", m, 6'h10);
    frame(P, H, 0, 5, 6'h3F, m, h, v);
    chk("R8 replacement H", m, 6'h01);

    // R5 lookup precedes learn
    frame(X, X, 0, 1, 6'h3F, m, h, v);
    chk("R5 self frame floods", m, 6'h3D);
    chk("R5 self frame miss", h, 0);
    frame(X, X, 0, 1, 6'h3F, m, h, v);
    chk("R5 second self frame filtered", m, 6'h00);
    chk("R5 second self frame hit", h, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule